// File: doc/BRIEF.md
# Cascadable Dual-Channel 32-Bit Counter

Two 16-bit counter channels, a lower one and an upper one, that run independently or are chained into a single 32-bit count. The upper channel holds bits 31:16 and the lower channel holds bits 15:0. The chaining is always in this one direction. Each channel counts in one of two ways:

- **Normal mode:** it counts ticks from a shared prescaler, which supplies the system clock divided by 1, 4, 16 or 64.
- **Phase-counting mode:** it counts a pair of quadrature phase inputs.

The upper channel's source select has a cascade code. With that code, the upper channel steps up when the lower channel wraps upward and steps down when the lower channel wraps downward.

Software reaches the block through a write strobe, a 3-bit select and a data word. The strobe and select write either control word or load either count. Both counts are always visible on output ports. Two single-cycle flags mark the chained 32-bit value wrapping up or wrapping down.

Each channel has its own quadrature decoder. The decoder is a four-state machine, with states PH_00, PH_10, PH_11 and PH_01, named after the synchronized {A,B} level. Its transitions are:

- **Forward step** (00→10→11→01→00): gives an up step.
- **Backward step** (the reverse order): gives a down step.
- **Hold** (no change): gives no step.
- **Ignored jump** (both phases change at once): gives no step.

Each counter channel chooses one action per cycle, in priority order: STEP_LOAD, then STEP_UP, then STEP_DOWN, then STEP_HOLD.

Top module: `cascade_counter32`

## Requirements
- R1: After reset both counts read 0, both control words are 0 (disabled), and `ovf32`/`unf32` are low.
- R2: A control word is written with `reg_sel`=0 (lower) or 2 (upper). Its fields are: bit 5 enable, bits 4:3 mode, bits 2:0 source. In normal mode (mode 2'b00) an enabled channel counts up by one per tick of the selected source. Source 3'b000 ticks every cycle, 3'b001 every 4 cycles, 3'b010 every 16 cycles and 3'b011 every 64 cycles. Any 64-cycle window therefore adds 64, 16, 4 or 1.
- R3: In normal mode, sources 3'b100 to 3'b110 stop the counter. Source 3'b111 also stops the lower channel. A cleared enable bit holds the count in every mode.
- R4: When the upper channel has source 3'b111 and is in normal mode, {hi,lo} behaves as one 32-bit up counter. The cycle in which lo goes from 16'hFFFF to 16'h0000 is also the cycle in which hi increments.
- R5: In phase-counting mode (mode 2'b01), each single change of either phase input changes the channel's count by one. A leads B gives up counts; B leads A gives down counts. The change appears three clock edges after the input changes, because of a two-flop synchronizer.
- R6: In cascade, a lower-channel underflow from 16'h0000 to 16'hFFFF decrements the upper count in that same cycle.
- R7: An upper channel in phase-counting mode ignores its source field, including 3'b111. It counts only its own phase inputs, and lower-channel wraps do not change it.
- R8: Counts are loaded with `reg_sel`=1 (lower) or 3 (upper). A load wins over a count event in the same cycle. A load of the lower count never carries into or borrows from the upper count.
- R9: `ovf32` is high for exactly the one cycle in which a cascaded 32-bit value shows 0 after wrapping up from 32'hFFFFFFFF. `unf32` is high for exactly the one cycle in which it shows 32'hFFFFFFFF after wrapping down from 0.
- R10: Writes with `reg_sel` 4 to 7 change neither count nor either control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 3 | Write target: 0 lower control, 1 lower count, 2 upper control, 3 upper count |
| reg_wdata | input | CNT_W | Write data |
| lo_pha | input | 1 | Lower channel phase A |
| lo_phb | input | 1 | Lower channel phase B |
| hi_pha | input | 1 | Upper channel phase A |
| hi_phb | input | 1 | Upper channel phase B |
| lo_count | output | CNT_W | Lower count (bits 15:0 when chained) |
| hi_count | output | CNT_W | Upper count (bits 31:16 when chained) |
| ovf32 | output | 1 | One-cycle chained upward wrap flag |
| unf32 | output | 1 | One-cycle chained downward wrap flag |

## Verification
The lower channel's wrap and the upper channel's step share one cycle. The bench sweeps the chained value through the 16'hFFFF boundary with the free-running system-clock source, and compares {hi,lo} every cycle against a 32-bit sum computed in the bench. It then steps the quadrature inputs through the 16'h0000 boundary in both directions.

A software load and a count event are also made to coincide. The bench writes 16'hFFFF and then, on the very next edge, a different value. This forces the load into the cycle that would otherwise carry, and the bench then checks that the upper count is unchanged.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic [2:0] src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] SEL_LO_CTRL = 3'd0;
    localparam logic [2:0] SEL_LO_CNT  = 3'd1;
    localparam logic [2:0] SEL_HI_CTRL = 3'd2;
    localparam logic [2:0] SEL_HI_CNT  = 3'd3;

    localparam logic [1:0] MODE_PHASE = 2'b01;

    localparam logic [2:0] SRC_CLK1  = 3'b000;
    localparam logic [2:0] SRC_DIV4  = 3'b001;
    localparam logic [2:0] SRC_DIV16 = 3'b010;
    localparam logic [2:0] SRC_DIV64 = 3'b011;
    localparam logic [2:0] SRC_CASC  = 3'b111;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } ph_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN,
        STEP_LOAD
    } step_t;

endpackage

// File: rtl/cc_prescale.sv
module cc_prescale #(
    parameter int TAP_SHIFT = 2,
    parameter int NUM_TAPS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tick
);
    localparam int PS_W = TAP_SHIFT * (NUM_TAPS - 1);

    logic [PS_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick[0] = 1'b1;

    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_tap
        assign tick[i] = &div_q[TAP_SHIFT*i-1:0];
        if (i >= 2) begin : g_nest
            // R2: a slower tap never ticks without the faster one
            a_r2_tap_nesting: assert property (@(posedge clk) disable iff (!rst_n)
                tick[i] |-> tick[i-1]);
        end
    end

endmodule

// File: rtl/cc_quad_dec.sv
module cc_quad_dec
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] a_sync, b_sync;
    ph_state_t  ph_q, ph_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sync <= '0;
            b_sync <= '0;
        end else begin
            a_sync <= {a_sync[0], ph_a};
            b_sync <= {b_sync[0], ph_b};
        end
    end

    assign ph_now = ph_state_t'({a_sync[1], b_sync[1]});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_00;
        else        ph_q <= ph_now;
    end

    // output decode: forward, backward, hold or ignored jump
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (ph_q)
            PH_00: begin
                step_up = (ph_now == PH_10);
                step_dn = (ph_now == PH_01);
            end
            PH_10: begin
                step_up = (ph_now == PH_11);
                step_dn = (ph_now == PH_00);
            end
            PH_11: begin
                step_up = (ph_now == PH_01);
                step_dn = (ph_now == PH_10);
            end
            PH_01: begin
                step_up = (ph_now == PH_00);
                step_dn = (ph_now == PH_11);
            end
        endcase
    end

    // R5: never both directions at once
    a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R5: a step only follows a single-bit phase change
    a_r5_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> ($countones(ph_q ^ ph_now) == 1));

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         wrap_up,
    output logic         wrap_dn
);
    localparam logic [W-1:0] CNT_MAX = '1;

    step_t step;

    always_comb begin
        if (load)     step = STEP_LOAD;
        else if (inc) step = STEP_UP;
        else if (dec) step = STEP_DOWN;
        else          step = STEP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (step)
                STEP_LOAD: cnt <= load_val;
                STEP_UP:   cnt <= cnt + 1'b1;
                STEP_DOWN: cnt <= cnt - 1'b1;
                STEP_HOLD: cnt <= cnt;
            endcase
        end
    end

    assign wrap_up = (step == STEP_UP)   && (cnt == CNT_MAX);
    assign wrap_dn = (step == STEP_DOWN) && (cnt == '0);

    // R8: a load takes effect over any count event
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R4: an upward wrap lands on zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> (cnt == '0));

    // R6: a downward wrap lands on all ones
    a_r6_wrap_to_max: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_dn |=> (cnt == CNT_MAX));

endmodule

// File: rtl/cascade_counter32.sv
module cascade_counter32
    import cc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PS_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             lo_pha,
    input  logic             lo_phb,
    input  logic             hi_pha,
    input  logic             hi_phb,
    output logic [CNT_W-1:0] lo_count,
    output logic [CNT_W-1:0] hi_count,
    output logic             ovf32,
    output logic             unf32
);
    localparam int NUM_CH   = 2;
    localparam int NUM_TAPS = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t ctrl_lo, ctrl_hi;
    logic [NUM_TAPS-1:0] tick;
    logic [NUM_CH-1:0]   ph_a, ph_b, q_up, q_dn;

    logic lo_inc, lo_dec, lo_load, lo_wrap_up, lo_wrap_dn;
    logic hi_inc, hi_dec, hi_load, hi_wrap_up, hi_wrap_dn;
    logic phase_lo, phase_hi, hi_casc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_lo <= '0;
            ctrl_hi <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_LO_CTRL) ctrl_lo <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_sel == SEL_HI_CTRL) ctrl_hi <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    cc_prescale #(.TAP_SHIFT(PS_SHIFT), .NUM_TAPS(NUM_TAPS)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign ph_a = {hi_pha, lo_pha};
    assign ph_b = {hi_phb, lo_phb};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        cc_quad_dec u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .ph_a    (ph_a[c]),
            .ph_b    (ph_b[c]),
            .step_up (q_up[c]),
            .step_dn (q_dn[c])
        );
    end

    function automatic logic pick_tick(input logic [2:0] src, input logic [NUM_TAPS-1:0] t);
        unique case (src)
            SRC_CLK1:  return t[0];
            SRC_DIV4:  return t[1];
            SRC_DIV16: return t[2];
            SRC_DIV64: return t[3];
            default:   return 1'b0;
        endcase
    endfunction

    assign phase_lo = (ctrl_lo.mode == MODE_PHASE);
    assign phase_hi = (ctrl_hi.mode == MODE_PHASE);
    assign hi_casc  = !phase_hi && (ctrl_hi.src == SRC_CASC);

    assign lo_load = reg_wr && (reg_sel == SEL_LO_CNT);
    assign hi_load = reg_wr && (reg_sel == SEL_HI_CNT);

    always_comb begin
        lo_inc = ctrl_lo.en && (phase_lo ? q_up[0] : pick_tick(ctrl_lo.src, tick));
        lo_dec = ctrl_lo.en && phase_lo && q_dn[0];
    end

    always_comb begin
        if (phase_hi) begin
            hi_inc = ctrl_hi.en && q_up[1];
            hi_dec = ctrl_hi.en && q_dn[1];
        end else if (hi_casc) begin
            hi_inc = ctrl_hi.en && lo_wrap_up;
            hi_dec = ctrl_hi.en && lo_wrap_dn;
        end else begin
            hi_inc = ctrl_hi.en && pick_tick(ctrl_hi.src, tick);
            hi_dec = 1'b0;
        end
    end

    cc_channel #(.W(CNT_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lo_load),
        .load_val (reg_wdata),
        .inc      (lo_inc),
        .dec      (lo_dec),
        .cnt      (lo_count),
        .wrap_up  (lo_wrap_up),
        .wrap_dn  (lo_wrap_dn)
    );

    cc_channel #(.W(CNT_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hi_load),
        .load_val (reg_wdata),
        .inc      (hi_inc),
        .dec      (hi_dec),
        .cnt      (hi_count),
        .wrap_up  (hi_wrap_up),
        .wrap_dn  (hi_wrap_dn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf32 <= 1'b0;
            unf32 <= 1'b0;
        end else begin
            ovf32 <= hi_casc && hi_wrap_up;
            unf32 <= hi_casc && hi_wrap_dn;
        end
    end

    // R4: lower upward wrap carries into the upper half in the same cycle
    a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_casc && ctrl_hi.en && !hi_load && lo_wrap_up) |=> (hi_count == $past(hi_count) + 1'b1));

    // R6: lower downward wrap borrows from the upper half in the same cycle
    a_r6_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_casc && ctrl_hi.en && !hi_load && lo_wrap_dn) |=> (hi_count == $past(hi_count) - 1'b1));

    // R8: a lower load never disturbs a cascaded upper half
    a_r8_no_carry_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_load && !hi_load && hi_casc) |=> $stable(hi_count));

    // R3: reserved sources freeze a normal-mode lower channel
    a_r3_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_lo && ctrl_lo.src[2] && !lo_load) |=> $stable(lo_count));

    // R7: a phase-mode upper channel moves only on its own phase steps
    a_r7_own_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_hi && !hi_load && !q_up[1] && !q_dn[1]) |=> $stable(hi_count));

    // R9: the flags are exclusive and mark the wrapped value
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf32, unf32}));
    a_r9_ovf_value: assert property (@(posedge clk) disable iff (!rst_n)
        ovf32 |-> (hi_count == '0 && lo_count == '0));
    a_r9_unf_value: assert property (@(posedge clk) disable iff (!rst_n)
        unf32 |-> (hi_count == CNT_MAX && lo_count == CNT_MAX));

endmodule

// File: tb/cascade_counter32_tb_top.sv
module cascade_counter32_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  pa = '0;
    logic [1:0]  pb = '0;
    logic [15:0] lo_count, hi_count;
    logic        ovf32, unf32;

    int n_chk = 0;
    int n_fail = 0;
    int ovf_seen = 0;
    int unf_seen = 0;

    always #10 clk = ~clk;

    cascade_counter32 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .lo_pha    (pa[0]),
        .lo_phb    (pb[0]),
        .hi_pha    (pa[1]),
        .hi_phb    (pb[1]),
        .lo_count  (lo_count),
        .hi_count  (hi_count),
        .ovf32     (ovf32),
        .unf32     (unf32)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ovf32) ovf_seen++;
            if (unf32) unf_seen++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // one quadrature step on channel ch (0 lower, 1 upper)
    task automatic qstep(input int ch, input bit up);
        if (up) begin
            if (pa[ch] == pb[ch]) pa[ch] = ~pa[ch];
            else                  pb[ch] = ~pb[ch];
        end else begin
            if (pa[ch] == pb[ch]) pb[ch] = ~pb[ch];
            else                  pa[ch] = ~pa[ch];
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] val32();
        return {hi_count, lo_count};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a, b;
        logic [31:0] v;
        int u0, o0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 counts", val32(), 32'h0);
        chk("R1 flags", {30'd0, ovf32, unf32}, 32'h0);

        // R10 writes to unused selects
        wr(3'd5, 16'hFFFF);
        wr(3'd4, 16'h003F);
        wr(3'd7, 16'h1234);
        repeat (70) @(negedge clk);
        chk("R10 no effect", val32(), 32'h0);

        // R2 prescaled sources over a 64-cycle window
        for (int s = 0; s < 4; s++) begin
            wr(3'd0, 16'h0020 | 16'(s));
            a = lo_count;
            repeat (64) @(negedge clk);
            b = lo_count;
            chk($sformatf("R2 src %0d rate", s), 32'(b - a), 32'(64 >> (2 * s)));
        end

        // R3 reserved sources and cascade code on lower channel stop it
        for (int s = 4; s < 8; s++) begin
            wr(3'd0, 16'h0020 | 16'(s));
            a = lo_count;
            repeat (70) @(negedge clk);
            chk($sformatf("R3 src %0d stopped", s), 32'(lo_count), 32'(a));
        end
        // R3 enable cleared holds
        wr(3'd0, 16'h0000);
        a = lo_count;
        repeat (20) @(negedge clk);
        chk("R3 disabled hold", 32'(lo_count), 32'(a));

        // R4 chained sweep across the lower boundary
        wr(3'd1, 16'hFFE8);
        wr(3'd3, 16'h1234);
        wr(3'd2, 16'h0027);
        wr(3'd0, 16'h0020);
        for (int k = 0; k < 40; k++) begin
            chk("R4 chained value", val32(), 32'h1234FFE8 + 32'(k));
            @(negedge clk);
        end

        // R9 32-bit upward wrap flag
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'hFFF0);
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'h0020);
        for (int k = 0; k < 32; k++) begin
            v = 32'hFFFFFFF0 + 32'(k);
            chk("R9 wrap value", val32(), v);
            chk("R9 ovf flag", {31'd0, ovf32}, {31'd0, (v == 32'h0)});
            @(negedge clk);
        end

        // R8 load wins over a carrying step; no carry from a load
        wr(3'd3, 16'h0042);
        wr(3'd1, 16'hFFFF);
        wr(3'd1, 16'h1000);
        chk("R8 lower loaded", 32'(lo_count), 32'h1000);
        chk("R8 upper untouched", 32'(hi_count), 32'h0042);
        wr(3'd0, 16'h0000);

        // R5 / R6 quadrature on lower, borrow through the boundary
        wr(3'd0, 16'h0028);
        wr(3'd1, 16'h0003);
        wr(3'd3, 16'h0001);
        repeat (4) @(negedge clk);
        for (int n = 1; n <= 8; n++) begin
            qstep(0, 1'b0);
            chk("R6 down/borrow", val32(), 32'h00010003 - 32'(n));
        end
        for (int n = 1; n <= 8; n++) begin
            qstep(0, 1'b1);
            chk("R5 up/carry", val32(), 32'h0000FFFB + 32'(n));
        end

        // R9 32-bit downward wrap flag
        wr(3'd1, 16'h0002);
        wr(3'd3, 16'h0000);
        u0 = unf_seen;
        o0 = ovf_seen;
        for (int n = 1; n <= 5; n++) begin
            qstep(0, 1'b0);
            chk("R9 down value", val32(), 32'h2 - 32'(n));
        end
        chk("R9 unf pulses", 32'(unf_seen - u0), 32'd1);
        chk("R9 no ovf", 32'(ovf_seen - o0), 32'd0);

        // R7 upper in phase mode ignores cascade
        wr(3'd2, 16'h002F);
        wr(3'd1, 16'hFFFE);
        wr(3'd3, 16'h0500);
        repeat (4) @(negedge clk);
        for (int n = 0; n < 4; n++) qstep(0, 1'b1);
        chk("R7 lower wrapped", 32'(lo_count), 32'h0002);
        chk("R7 upper ignores wrap", 32'(hi_count), 32'h0500);
        for (int n = 0; n < 3; n++) qstep(1, 1'b1);
        chk("R7 upper own up", 32'(hi_count), 32'h0503);
        qstep(1, 1'b0);
        chk("R7 upper own down", 32'(hi_count), 32'h0502);
        chk("R7 lower unchanged", 32'(lo_count), 32'h0002);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule